// File: doc/BRIEF.md
# Microcontroller I/O Port Pair with Alternate Functions

This block holds the general-purpose I/O ports of a small 8-bit microcontroller, reached over the special-function-register (SFR) bus. One parameterized port module is instantiated twice. The first instance is an eight-bit port that also carries serial data, external interrupt, timer count and external-memory strobe functions. The second is a four-bit port decoded at SFR address 0xD8.

Each pin has one output latch bit. The pin output is the latch ANDed with the alternate-function output. The core holds an alternate output at 1 when that function is idle, so the latch then drives the pin on its own. Pin levels pass through a two-flop synchronizer. The synchronized levels feed the pin-read path and the alternate-function inputs.

A read that the instruction decoder marks as read-modify-write returns the latches, so that a logical operation on the port acts on the value that was written to it. Every other read returns the live pin levels.

Top module: `io_port_pair`

## Requirements
- R1: After reset every latch bit of both ports is 1, and every pin output is 1.
- R2: A write strobe with an address that matches a port loads the write data into that port's latch at the next rising clock edge.
- R3: A write to an address that matches neither port leaves both latches unchanged.
- R4: A read marked read-modify-write returns the port latch. On the four-bit port, read data bits 7..4 are 1.
- R5: A plain read returns the synchronized pin levels. A pin change becomes visible after two rising clock edges and not after one.
- R6: Each pin output equals its latch bit ANDed with its alternate output. Eight-bit port alternate outputs: bit 0 is serial receive/data drive, bit 1 is serial transmit/shift clock, bit 6 is the memory write strobe, bit 7 is the memory read strobe. Bits 2..5 are held at 1.
- R7: The alternate inputs follow the synchronized eight-bit pin levels: serial data in = bit 0, interrupt 0 = bit 2, interrupt 1 = bit 3, timer 0 count = bit 4, timer 1 count = bit 5.
- R8: On the four-bit port, write data bits 7..4 have no effect, and those bits read as 1 on both kinds of read.
- R9: Read data is 0x00 when the read strobe is low or the address matches neither port.
- R10: If a pin is driven low externally while its latch holds 1, a read-modify-write read returns 1 for that bit and a plain read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_rmw | input | 1 | Marks a read as read-modify-write |
| sfr_rdata | output | 8 | Read data, 0 when no port is selected |
| pa_pin_in | input | 8 | Eight-bit port pin levels |
| pa_pin_out | output | 8 | Eight-bit port pin drive |
| ser_rxd_drv | input | 1 | Serial data output from the core, alternate output of bit 0 |
| ser_txd_drv | input | 1 | Serial transmit or shift clock, alternate output of bit 1 |
| xmem_wr_n | input | 1 | Memory write strobe, alternate output of bit 6 |
| xmem_rd_n | input | 1 | Memory read strobe, alternate output of bit 7 |
| ser_rxd_in | output | 1 | Synchronized bit 0 |
| int0_in | output | 1 | Synchronized bit 2 |
| int1_in | output | 1 | Synchronized bit 3 |
| t0_in | output | 1 | Synchronized bit 4 |
| t1_in | output | 1 | Synchronized bit 5 |
| pb_pin_in | input | 4 | Four-bit port pin levels |
| pb_pin_out | output | 4 | Four-bit port pin drive |

## Verification
The assertions assume that the two port addresses are distinct. They also assume that the read-modify-write qualifier matters only while a read strobe is high. The latch check further assumes that write data is stable for the one cycle in which the strobe is high.

The stimulus sets every bus input at falling edges and holds each strobe for exactly one cycle. It draws addresses only from the two port addresses and one unmapped address. After each pin change it waits at least three edges before comparing a plain read with the pins that were driven.

// File: rtl/io_port.sv
module io_port #(
  parameter int W = 8,
  parameter logic [7:0] ADDR = 8'hB0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   sfr_addr,
  input  logic [7:0]   sfr_wdata,
  input  logic         sfr_wr,
  input  logic         sfr_rd,
  input  logic         sfr_rmw,
  output logic [7:0]   rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] alt_in
);
  localparam int PAD = 8 - W;

  logic [W-1:0] latch, s1, s2;
  logic hit;
  logic [7:0] sel;

  assign hit = (sfr_addr == ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) latch <= '1;
    else if (sfr_wr && hit) latch <= sfr_wdata[W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end

  assign pin_out = latch & alt_out;
  assign alt_in  = s2;

  generate
    if (PAD > 0) begin : g_pad
      assign sel = {{PAD{1'b1}}, sfr_rmw ? latch : s2};
    end else begin : g_full
      assign sel = sfr_rmw ? latch : s2;
    end
  endgenerate

  assign rdata = (sfr_rd && hit) ? sel : 8'h00;

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && hit) |=> pin_out == ($past(sfr_wdata[W-1:0]) & alt_out));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_wr && hit) |=> $stable(latch));
  p_rmw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && hit && sfr_rmw && (&alt_out)) |-> rdata[W-1:0] == pin_out);
  p_pinrd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && hit && !sfr_rmw) |-> rdata[W-1:0] == alt_in);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_rd && hit) |-> rdata == 8'h00);
  generate
    if (PAD > 0) begin : g_chk_pad
      p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && hit) |-> (&rdata[7:W]));
    end
  endgenerate
endmodule

// File: rtl/io_port_pair.sv
module io_port_pair #(
  parameter logic [7:0] PA_ADDR = 8'hB0,
  parameter logic [7:0] PB_ADDR = 8'hD8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  input  logic       sfr_rmw,
  output logic [7:0] sfr_rdata,
  input  logic [7:0] pa_pin_in,
  output logic [7:0] pa_pin_out,
  input  logic       ser_rxd_drv,
  input  logic       ser_txd_drv,
  input  logic       xmem_wr_n,
  input  logic       xmem_rd_n,
  output logic       ser_rxd_in,
  output logic       int0_in,
  output logic       int1_in,
  output logic       t0_in,
  output logic       t1_in,
  input  logic [3:0] pb_pin_in,
  output logic [3:0] pb_pin_out
);
  logic [7:0] pa_rdata, pb_rdata, pa_alt_out, pa_alt_in;
  logic [3:0] pb_alt_in;

  assign pa_alt_out = {xmem_rd_n, xmem_wr_n, 4'hF, ser_txd_drv, ser_rxd_drv};

  io_port #(.W(8), .ADDR(PA_ADDR)) u_pa (
    .clk, .rst_n, .sfr_addr, .sfr_wdata, .sfr_wr, .sfr_rd, .sfr_rmw,
    .rdata(pa_rdata), .pin_in(pa_pin_in), .pin_out(pa_pin_out),
    .alt_out(pa_alt_out), .alt_in(pa_alt_in));

  io_port #(.W(4), .ADDR(PB_ADDR)) u_pb (
    .clk, .rst_n, .sfr_addr, .sfr_wdata, .sfr_wr, .sfr_rd, .sfr_rmw,
    .rdata(pb_rdata), .pin_in(pb_pin_in), .pin_out(pb_pin_out),
    .alt_out(4'hF), .alt_in(pb_alt_in));

  assign sfr_rdata  = pa_rdata | pb_rdata;
  assign ser_rxd_in = pa_alt_in[0];
  assign int0_in    = pa_alt_in[2];
  assign int1_in    = pa_alt_in[3];
  assign t0_in      = pa_alt_in[4];
  assign t1_in      = pa_alt_in[5];

  p_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xmem_rd_n || !ser_txd_drv) |-> !(pa_pin_out[7] && pa_pin_out[1] && !xmem_rd_n)
                                    && !(pa_pin_out[1] && !ser_txd_drv));
endmodule

// File: tb/sim_io_port_pair.sv
module sim_io_port_pair;
  localparam logic [7:0] PA = 8'hB0, PB = 8'hD8, NX = 8'h80;
  logic clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic sfr_wr = 0, sfr_rd = 0, sfr_rmw = 0;
  logic [7:0] pa_pin_in = 8'hFF, pa_pin_out;
  logic [3:0] pb_pin_in = 4'hF, pb_pin_out;
  logic ser_rxd_drv = 1, ser_txd_drv = 1, xmem_wr_n = 1, xmem_rd_n = 1;
  logic ser_rxd_in, int0_in, int1_in, t0_in, t1_in;
  int tests = 0, fails = 0;
  logic [7:0] lat_a, rd;
  logic [3:0] lat_b;

  always #2.5 clk = ~clk;

  io_port_pair u0 (.*);

  function automatic logic [7:0] exp_read(logic [7:0] a, logic rmw);
    if (a == PA) return rmw ? lat_a : pa_pin_in;
    if (a == PB) return {4'hF, rmw ? lat_b : pb_pin_in};
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_pa_out();
    return lat_a & {xmem_rd_n, xmem_wr_n, 4'hF, ser_txd_drv, ser_rxd_drv};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(negedge clk);
    sfr_wr = 0;
    if (a == PA) lat_a = d;
    if (a == PB) lat_b = d[3:0];
  endtask

  task automatic rdp(logic [7:0] a, logic rmw, output logic [7:0] v);
    @(negedge clk);
    sfr_addr = a; sfr_rmw = rmw; sfr_rd = 1;
    #1 v = sfr_rdata;
    @(negedge clk);
    sfr_rd = 0; sfr_rmw = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    lat_a = 8'hFF; lat_b = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pa_pin_out", pa_pin_out, 8'hFF);
    chk("R1 pb_pin_out", {4'h0, pb_pin_out}, 8'h0F);
    rdp(PA, 1, rd); chk("R1/R4 pa latch", rd, 8'hFF);
    rdp(PB, 1, rd); chk("R1/R4 pb latch", rd, 8'hFF);

    // R2 write and R4 read back
    wr(PA, 8'h5A); chk("R2 pa_pin_out", pa_pin_out, 8'h5A);
    rdp(PA, 1, rd); chk("R4 pa rmw", rd, 8'h5A);
    // R8 upper bits ignored
    wr(PB, 8'h06); chk("R8 pb_pin_out", {4'h0, pb_pin_out}, 8'h06);
    rdp(PB, 1, rd); chk("R8 pb rmw upper ones", rd, 8'hF6);
    rdp(PB, 0, rd); chk("R8 pb plain upper ones", rd, 8'hFF);
    // R3 unmapped write
    wr(NX, 8'h00);
    chk("R3 pa unchanged", pa_pin_out, 8'h5A);
    chk("R3 pb unchanged", {4'h0, pb_pin_out}, 8'h06);
    // R9
    rdp(NX, 0, rd); chk("R9 unmapped read", rd, 8'h00);
    #1 chk("R9 idle rdata", sfr_rdata, 8'h00);

    // R6 alternate outputs
    wr(PA, 8'hFF);
    @(negedge clk); ser_txd_drv = 0; xmem_rd_n = 0;
    #1 chk("R6 alt gating", pa_pin_out, 8'h7D);
    @(negedge clk); ser_txd_drv = 1; xmem_rd_n = 1; ser_rxd_drv = 0; xmem_wr_n = 0;
    #1 chk("R6 alt gating 2", pa_pin_out, 8'hBE);
    @(negedge clk); ser_rxd_drv = 1; xmem_wr_n = 1;

    // R5 latency and R7 alternate inputs
    @(negedge clk); pa_pin_in = 8'hC3;
    @(negedge clk);
    chk("R7 not yet (one edge)", {3'b0, t1_in, t0_in, int1_in, int0_in, ser_rxd_in}, 8'h1F);
    @(negedge clk);
    chk("R7 alt inputs", {3'b0, t1_in, t0_in, int1_in, int0_in, ser_rxd_in}, 8'h01);
    rdp(PA, 0, rd); chk("R5 plain pin read", rd, 8'hC3);

    // R10 external driver pulls a pin low
    wr(PB, 8'h0F);
    @(negedge clk); pb_pin_in = 4'hB;
    settle();
    rdp(PB, 1, rd); chk("R10 rmw returns latch", rd, 8'hFF);
    rdp(PB, 0, rd); chk("R10 plain returns pin", rd, 8'hFB);

    // random mix
    for (int i = 0; i < 80; i++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] a;
      case ($urandom_range(0, 2)) 0: a = PA; 1: a = PB; default: a = NX; endcase
      if (op == 0) begin
        wr(a, 8'($urandom));
        chk("R2/R3 rand pa_pin_out", pa_pin_out, exp_pa_out());
        chk("R2/R3 rand pb_pin_out", {4'h0, pb_pin_out}, {4'h0, lat_b});
      end else if (op == 1) begin
        @(negedge clk);
        pa_pin_in = 8'($urandom); pb_pin_in = 4'($urandom);
        settle();
      end else begin
        logic rmw = (op == 3);
        rdp(a, rmw, rd);
        chk(rmw ? "R4 rand rmw read" : "R5 rand plain read", rd, exp_read(a, rmw));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule